// File: doc/BRIEF.md
# Serial Switch-Register Access Master

This block lets on-chip logic read and write the configuration and counter registers of an external Ethernet switch device. The device is reached over a three-wire serial link of the kind used by small serial EEPROMs: a select line, a clock that idles low, and one data line. The data line is bidirectional, so the block drives it through a separate output enable. Every pin the block drives has such an enable, so all three can be released when the link is not in use.

A host requests a transaction with a single-cycle `req_start` pulse. The pulse carries the direction, a table select, a register address and 16 bits of write data. The block builds the complete bit frame, including the long all-ones lead-in of a read, the data-line turnaround and the extra trailing clocks. It times every clock level and setup interval from the system clock, with `CLKS_PER_US` system clocks counting as one microsecond. When the transaction ends, `done` pulses for one cycle and `rd_data` holds the result. A table-0 read returns one of two 16-bit registers, chosen by address parity. A table-1 read returns a full 32-bit counter.

Control is a single state machine.
- `S_IDLE` goes to `S_ENABLE` on an accepted start.
- `S_ENABLE` leads to `S_SELECT`, then to the bit loop `S_TX_LOW` → `S_TX_SETUP` → `S_TX_HIGH`. The loop returns to `S_TX_LOW` until the last command bit, then leaves for `S_TX_END`.
- After `S_TX_END`, a read goes to `S_TURN_REL` and a write goes straight to the pulse pair.
- The pulse pair is `S_PULSE_HI` → `S_PULSE_LO`, done twice.
- After the turnaround pulses, a read runs `S_RX_SELECT`, then the capture loop `S_RX_LOW` → `S_RX_HIGH`, then `S_RX_END`, then a second pulse pair.
- Every trailing pulse pair ends in `S_RELEASE`, then `S_DONE`, then `S_IDLE`.

Each timed state lasts one full edge time, except `S_TX_SETUP`, which lasts one setup time, and `S_DONE`, which lasts one cycle.

Top module: `swreg_serial_master`

## Requirements
- R1: Out of reset and while idle, `busy` and `done` are 0, `sio_clk` is 0 and all three output enables are 0.
- R2: A start pulse seen while `busy` is 0 is accepted. From the next cycle `busy` is 1, and all three enables are 1 with all three driven values 0, before any clock edge.
- R3: A start pulse while `busy` is 1 is ignored. The frame in progress, its result and its length are unchanged.
- R4: Every clock high or low level lasts at least 3·`CLKS_PER_US` system clocks. The driven data value changes at least `CLKS_PER_US` clocks before the rising edge that uses it and never while the clock is high. Select is settled at least `CLKS_PER_US` clocks before the first rising edge.
- R5: A read sends 46 bits, most significant first, with select held at 0. The bits are 32 ones, then 0,1,1,0, then the table bit, then two zeros, then address bits 6..0.
- R6: After a read command the data enable drops before further clocking. Two turnaround rising edges follow, then 32 capture edges, each bit sampled while the clock is low just before its rising edge, then two trailing edges. That makes 82 rising edges in all, and the data enable is 0 for the last 36 of them.
- R7: For table 0, `rd_data` holds the captured upper 16 bits when address bit 0 is 1 and the lower 16 bits when it is 0, with bits 31..16 zero. For table 1 it holds all 32 captured bits, first captured bit at bit 31.
- R8: A write sends 27 bits, most significant first, with select at 1: a 1, then 0,1, then address bits 7..0, then data bits 15..0. Select then falls, and two more rising edges follow with select at 0, making 29 rising edges.
- R9: `done` is 1 for exactly one cycle, with `busy` still 1 and all enables already 0. `busy` is 0 in the next cycle. `rd_data` is 0 after a write. With E = 3·`CLKS_PER_US` and S = `CLKS_PER_US`, `done` appears 171·E+46·S+1 cycles after the accepting edge for a read and 62·E+27·S+1 cycles after it for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Single-cycle request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_table | input | 1 | Read table select (0 = 16-bit registers, 1 = 32-bit counters) |
| req_addr | input | 8 | Register address (reads use bits 6..0) |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with `done` |
| sio_cs | output | 1 | Select value |
| sio_cs_oe | output | 1 | Select output enable |
| sio_clk | output | 1 | Serial clock value |
| sio_clk_oe | output | 1 | Serial clock output enable |
| sio_dout | output | 1 | Data value driven toward the device |
| sio_dout_oe | output | 1 | Data output enable |
| sio_din | input | 1 | Data value seen on the pin |

## Verification
The pin state set up by a start is due one cycle after the accepting edge. The bench checks it at the first falling edge after the start is driven. `done` is due a fixed number of cycles later: 1119 for a read and 427 for a write at the bench setting of two system clocks per microsecond. The bench counts falling edges from the start and compares the count at which `done` appears against the R9 formula. It reads `rd_data`, the enables and the recorded frame in that same cycle, then checks the return to idle one cycle later. A monitor samples the pins on every falling system-clock edge and records the select, data and enable values at each serial rising edge. It feeds the read pattern back one bit after each rising edge, so each bit is in place a full low level before the master samples it.

// File: rtl/swreg_pkg.sv
`timescale 1ns/1ps
package swreg_pkg;

    // Frame geometry of the serial link (fixed by the device protocol)
    localparam int RD_CMD_BITS  = 46;
    localparam int WR_CMD_BITS  = 27;
    localparam int CMD_W        = RD_CMD_BITS;
    localparam int RD_DATA_BITS = 32;
    localparam int HALF_BITS    = RD_DATA_BITS / 2;
    localparam int EXTRA_PULSES = 2;
    localparam int BITCNT_W     = $clog2(CMD_W);
    localparam int PULSE_W      = (EXTRA_PULSES > 1) ? $clog2(EXTRA_PULSES) : 1;

    // Read command field values
    localparam logic [31:0] RD_LEADIN = 32'hFFFF_FFFF;
    localparam logic [3:0]  RD_OPCODE = 4'b0110;
    localparam logic [1:0]  RD_DEVID  = 2'b00;
    // Write command field values
    localparam logic [2:0]  WR_OPCODE = 3'b101;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENABLE,
        S_SELECT,
        S_TX_LOW,
        S_TX_SETUP,
        S_TX_HIGH,
        S_TX_END,
        S_TURN_REL,
        S_PULSE_HI,
        S_PULSE_LO,
        S_RX_SELECT,
        S_RX_LOW,
        S_RX_HIGH,
        S_RX_END,
        S_RELEASE,
        S_DONE
    } sio_state_e;

    typedef enum logic [1:0] {
        LEN_EDGE,
        LEN_SETUP,
        LEN_ONE
    } phase_len_e;

endpackage

// File: rtl/swreg_phase_timer.sv
`timescale 1ns/1ps
module swreg_phase_timer
    import swreg_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int EDGE_US     = 3,
    parameter int SETUP_US    = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  phase_len_e len_kind,
    output logic       expired
);

    localparam int EDGE_CLKS  = EDGE_US * CLKS_PER_US;
    localparam int SETUP_CLKS = SETUP_US * CLKS_PER_US;
    localparam int MAX_CLKS   = (EDGE_CLKS > SETUP_CLKS) ? EDGE_CLKS : SETUP_CLKS;
    localparam int CW         = $clog2(MAX_CLKS + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] reload;

    always_comb begin
        unique case (len_kind)
            LEN_EDGE:  reload = CW'(EDGE_CLKS - 1);
            LEN_SETUP: reload = CW'(SETUP_CLKS - 1);
            default:   reload = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R4: a phase never lasts longer than the longest configured level
    a_r4_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX_CLKS - 1));

endmodule

// File: rtl/swreg_cmd_shifter.sv
`timescale 1ns/1ps
module swreg_cmd_shifter
    import swreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        is_write,
    input  logic        table_sel,
    input  logic [7:0]  addr,
    input  logic [15:0] wdata,
    input  logic        shift,
    output logic        msb
);

    localparam int WR_PAD = CMD_W - WR_CMD_BITS;

    logic [CMD_W-1:0] frame_q;
    logic [CMD_W-1:0] rd_frame;
    logic [CMD_W-1:0] wr_frame;

    // Read: lead-in, start/opcode, table, device id, 7-bit address
    assign rd_frame = {RD_LEADIN, RD_OPCODE, table_sel, RD_DEVID, addr[6:0]};
    // Write: start+opcode, 8-bit address, 16-bit data, left aligned
    assign wr_frame = {WR_OPCODE, addr, wdata, {WR_PAD{1'b0}}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= is_write ? wr_frame : rd_frame;
        end else if (shift) begin
            frame_q <= {frame_q[CMD_W-2:0], 1'b0};
        end
    end

    assign msb = frame_q[CMD_W-1];

endmodule

// File: rtl/swreg_rx_capture.sv
`timescale 1ns/1ps
module swreg_rx_capture
    import swreg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    sample,
    input  logic                    din,
    input  logic                    table_sel,
    input  logic                    addr_lsb,
    output logic [RD_DATA_BITS-1:0] result
);

    logic [RD_DATA_BITS-1:0] cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (clear) begin
            cap_q <= '0;
        end else if (sample) begin
            cap_q <= {cap_q[RD_DATA_BITS-2:0], din};
        end
    end

    // Table 0 carries a register pair; parity of the address picks one half
    always_comb begin
        if (table_sel) begin
            result = cap_q;
        end else if (addr_lsb) begin
            result = {{HALF_BITS{1'b0}}, cap_q[RD_DATA_BITS-1:HALF_BITS]};
        end else begin
            result = {{HALF_BITS{1'b0}}, cap_q[HALF_BITS-1:0]};
        end
    end

endmodule

// File: rtl/swreg_serial_master.sv
`timescale 1ns/1ps
module swreg_serial_master
    import swreg_pkg::*;
#(
    parameter int CLKS_PER_US = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_start,
    input  logic        req_write,
    input  logic        req_table,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [31:0] rd_data,
    output logic        sio_cs,
    output logic        sio_cs_oe,
    output logic        sio_clk,
    output logic        sio_clk_oe,
    output logic        sio_dout,
    output logic        sio_dout_oe,
    input  logic        sio_din
);

    sio_state_e state_q, state_d;

    logic                    accept;
    logic                    tmr_zero;
    logic                    tmr_load;
    phase_len_e              tmr_kind;
    logic                    wr_q;
    logic                    tbl_q;
    logic [7:0]              addr_q;
    logic [BITCNT_W-1:0]     bit_left_q;
    logic [PULSE_W-1:0]      pulse_left_q;
    logic                    trail_q;
    logic                    dat_q;
    logic                    sel_q;
    logic [RD_DATA_BITS-1:0] rd_q;
    logic                    frame_msb;
    logic [RD_DATA_BITS-1:0] rx_result;
    logic                    bit_last;
    logic                    pulse_last;
    logic                    leave;

    assign accept     = (state_q == S_IDLE) && req_start;
    assign bit_last   = (bit_left_q == '0);
    assign pulse_last = (pulse_left_q == '0);
    assign leave      = tmr_zero;

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (req_start) state_d = S_ENABLE;
            S_ENABLE:    if (leave) state_d = S_SELECT;
            S_SELECT:    if (leave) state_d = S_TX_LOW;
            S_TX_LOW:    if (leave) state_d = S_TX_SETUP;
            S_TX_SETUP:  if (leave) state_d = S_TX_HIGH;
            S_TX_HIGH:   if (leave) state_d = bit_last ? S_TX_END : S_TX_LOW;
            S_TX_END:    if (leave) state_d = wr_q ? S_PULSE_HI : S_TURN_REL;
            S_TURN_REL:  if (leave) state_d = S_PULSE_HI;
            S_PULSE_HI:  if (leave) state_d = S_PULSE_LO;
            S_PULSE_LO:  if (leave) begin
                             if (!pulse_last)  state_d = S_PULSE_HI;
                             else if (trail_q) state_d = S_RELEASE;
                             else              state_d = S_RX_SELECT;
                         end
            S_RX_SELECT: if (leave) state_d = S_RX_LOW;
            S_RX_LOW:    if (leave) state_d = S_RX_HIGH;
            S_RX_HIGH:   if (leave) state_d = bit_last ? S_RX_END : S_RX_LOW;
            S_RX_END:    if (leave) state_d = S_PULSE_HI;
            S_RELEASE:   if (leave) state_d = S_DONE;
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- phase timer ----------------
    assign tmr_load = (state_d != state_q);

    always_comb begin
        if (state_d == S_TX_SETUP) begin
            tmr_kind = LEN_SETUP;
        end else if (state_d == S_DONE || state_d == S_IDLE) begin
            tmr_kind = LEN_ONE;
        end else begin
            tmr_kind = LEN_EDGE;
        end
    end

    swreg_phase_timer #(
        .CLKS_PER_US (CLKS_PER_US),
        .EDGE_US     (3),
        .SETUP_US    (1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .len_kind (tmr_kind),
        .expired  (tmr_zero)
    );

    // ---------------- command frame ----------------
    swreg_cmd_shifter u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .is_write  (req_write),
        .table_sel (req_table),
        .addr      (req_addr),
        .wdata     (req_wdata),
        .shift     ((state_q == S_TX_HIGH) && leave),
        .msb       (frame_msb)
    );

    // ---------------- read capture ----------------
    swreg_rx_capture u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample    ((state_q == S_RX_LOW) && leave),
        .din       (sio_din),
        .table_sel (tbl_q),
        .addr_lsb  (addr_q[0]),
        .result    (rx_result)
    );

    // ---------------- sequencing datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q         <= 1'b0;
            tbl_q        <= 1'b0;
            addr_q       <= '0;
            bit_left_q   <= '0;
            pulse_left_q <= '0;
            trail_q      <= 1'b0;
            dat_q        <= 1'b0;
            sel_q        <= 1'b0;
            rd_q         <= '0;
        end else if (accept) begin
            wr_q         <= req_write;
            tbl_q        <= req_table;
            addr_q       <= req_addr;
            bit_left_q   <= req_write ? BITCNT_W'(WR_CMD_BITS - 1) : BITCNT_W'(RD_CMD_BITS - 1);
            pulse_left_q <= PULSE_W'(EXTRA_PULSES - 1);
            trail_q      <= 1'b0;
            dat_q        <= 1'b0;
            sel_q        <= 1'b0;
            rd_q         <= '0;
        end else if (leave) begin
            unique case (state_q)
                S_ENABLE:   sel_q <= wr_q;
                S_TX_LOW:   dat_q <= frame_msb;
                S_TX_HIGH:  if (!bit_last) bit_left_q <= bit_left_q - 1'b1;
                S_TX_END: begin
                    sel_q        <= 1'b0;
                    pulse_left_q <= PULSE_W'(EXTRA_PULSES - 1);
                    trail_q      <= wr_q;
                end
                S_TURN_REL: pulse_left_q <= PULSE_W'(EXTRA_PULSES - 1);
                S_PULSE_LO: begin
                    if (!pulse_last) begin
                        pulse_left_q <= pulse_left_q - 1'b1;
                    end else if (!trail_q) begin
                        bit_left_q <= BITCNT_W'(RD_DATA_BITS - 1);
                    end
                end
                S_RX_HIGH:  if (!bit_last) bit_left_q <= bit_left_q - 1'b1;
                S_RX_END: begin
                    rd_q         <= rx_result;
                    pulse_left_q <= PULSE_W'(EXTRA_PULSES - 1);
                    trail_q      <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---------------- output decode ----------------
    always_comb begin
        busy        = (state_q != S_IDLE);
        done        = (state_q == S_DONE);
        sio_clk     = 1'b0;
        sio_clk_oe  = 1'b0;
        sio_cs_oe   = 1'b0;
        sio_dout_oe = 1'b0;
        unique case (state_q)
            S_IDLE, S_RELEASE, S_DONE: ;
            S_ENABLE, S_SELECT, S_TX_LOW, S_TX_SETUP, S_TX_END: begin
                sio_clk_oe  = 1'b1;
                sio_cs_oe   = 1'b1;
                sio_dout_oe = 1'b1;
            end
            S_TX_HIGH: begin
                sio_clk     = 1'b1;
                sio_clk_oe  = 1'b1;
                sio_cs_oe   = 1'b1;
                sio_dout_oe = 1'b1;
            end
            S_PULSE_HI, S_RX_HIGH: begin
                sio_clk     = 1'b1;
                sio_clk_oe  = 1'b1;
                sio_cs_oe   = 1'b1;
                sio_dout_oe = wr_q;
            end
            default: begin
                sio_clk_oe  = 1'b1;
                sio_cs_oe   = 1'b1;
                sio_dout_oe = wr_q;
            end
        endcase
    end

    assign sio_cs   = sel_q;
    assign sio_dout = dat_q;
    assign rd_data  = rd_q;

    // ---------------- assertions ----------------
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sio_clk_oe && !sio_cs_oe && !sio_dout_oe && !sio_clk));

    a_r2_enable_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (sio_cs_oe && sio_clk_oe && sio_dout_oe && !sio_cs && !sio_clk && !sio_dout));

    a_r3_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(wr_q) && $stable(tbl_q) && $stable(addr_q)));

    a_r4_dout_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sio_clk && $past(sio_clk)) |-> $stable(sio_dout));

    a_r6_released_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {S_TURN_REL, S_RX_SELECT, S_RX_LOW, S_RX_HIGH, S_RX_END}) |-> !sio_dout_oe);

    a_r8_select_only_write: assert property (@(posedge clk) disable iff (!rst_n)
        sio_cs |-> wr_q);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

endmodule

// File: tb/swreg_serial_master_bench.sv
`timescale 1ns/1ps
module swreg_serial_master_bench;

    localparam int C = 2;
    localparam int E = 3 * C;
    localparam int S = C;
    localparam int RD_CYCLES = 171 * E + 46 * S + 1;
    localparam int WR_CYCLES = 62 * E + 27 * S + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic        req_table = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rd_data;
    logic        sio_cs, sio_cs_oe, sio_clk, sio_clk_oe, sio_dout, sio_dout_oe;
    logic        sio_din = 1'b0;

    always #2.5 clk = ~clk;

    swreg_serial_master #(.CLKS_PER_US(C)) u_swreg_serial_master (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_start   (req_start),
        .req_write   (req_write),
        .req_table   (req_table),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .done        (done),
        .rd_data     (rd_data),
        .sio_cs      (sio_cs),
        .sio_cs_oe   (sio_cs_oe),
        .sio_clk     (sio_clk),
        .sio_clk_oe  (sio_clk_oe),
        .sio_dout    (sio_dout),
        .sio_dout_oe (sio_dout_oe),
        .sio_din     (sio_din)
    );

    int checks = 0;
    int fails = 0;
    int mon_checks = 0;
    int mon_fails = 0;
    logic [31:0] pat = '0;

    // ---------------- responder / pin monitor ----------------
    logic [127:0] log_d = '0, log_cs = '0, log_oe = '0;
    int   rises = 0;
    int   lvl_cnt = 0, dat_age = 0, sel_age = 0;
    logic sck_prev = 1'b0, dat_prev = 1'b0, sel_prev = 1'b0;

    always @(negedge clk) begin
        if (!busy) begin
            rises   = 0;
            sio_din = 1'b0;
        end
        if (sio_dout != dat_prev) dat_age = 0; else if (dat_age < 1000) dat_age++;
        if (sio_cs != sel_prev) sel_age = 0; else if (sel_age < 1000) sel_age++;
        if (sio_clk != sck_prev) begin
            if (busy) begin
                mon_checks++;
                if (lvl_cnt < E) begin
                    mon_fails++;
                    $display("FAIL R4 clock level run actual=%0d expected>=%0d", lvl_cnt, E);
                end
            end
            lvl_cnt = 1;
        end else begin
            lvl_cnt++;
        end
        if (sio_clk && !sck_prev) begin
            if (rises < 128) begin
                log_d[rises]  = sio_dout;
                log_cs[rises] = sio_cs;
                log_oe[rises] = sio_dout_oe;
            end
            if (sio_dout_oe) begin
                mon_checks++;
                if (dat_age < C) begin
                    mon_fails++;
                    $display("FAIL R4 data setup actual=%0d expected>=%0d", dat_age, C);
                end
            end
            if (rises == 0) begin
                mon_checks++;
                if (sel_age < C) begin
                    mon_fails++;
                    $display("FAIL R4 select setup actual=%0d expected>=%0d", sel_age, C);
                end
            end
            rises++;
            sio_din = (rises >= 48 && rises < 80) ? pat[79 - rises] : 1'b0;
        end
        sck_prev = sio_clk;
        dat_prev = sio_dout;
        sel_prev = sio_cs;
    end

    // ---------------- helpers ----------------
    task automatic chk(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [45:0] exp_rd_frame(input logic tbl, input logic [7:0] a);
        return {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, a[6:0]};
    endfunction

    function automatic logic [26:0] exp_wr_frame(input logic [7:0] a, input logic [15:0] d);
        return {1'b1, 2'b01, a, d};
    endfunction

    function automatic logic [31:0] exp_result(input logic wr, input logic tbl,
                                               input logic [7:0] a, input logic [31:0] p);
        if (wr)   return 32'h0;
        if (tbl)  return p;
        if (a[0]) return {16'h0, p[31:16]};
        return {16'h0, p[15:0]};
    endfunction

    task automatic run_txn(input logic wr, input logic tbl, input logic [7:0] addr,
                           input logic [15:0] wd, input logic [31:0] p, input logic poke);
        int lat;
        int exp_lat;
        logic [45:0] got_rd;
        logic [26:0] got_wr;
        @(negedge clk);
        chk(busy == 1'b0, "R2", "idle before start", 64'(busy), 64'h0);
        pat       = p;
        req_write = wr;
        req_table = tbl;
        req_addr  = addr;
        req_wdata = wd;
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R2", "busy after accept", 64'(busy), 64'h1);
        chk({sio_cs_oe, sio_clk_oe, sio_dout_oe, sio_cs, sio_clk, sio_dout} == 6'b111000,
            "R2", "pins enabled low", 64'({sio_cs_oe, sio_clk_oe, sio_dout_oe, sio_cs, sio_clk, sio_dout}),
            64'b111000);
        if (poke) begin
            repeat (20) @(negedge clk);
            lat += 20;
            req_start = 1'b1;
            req_write = ~wr;
            req_table = ~tbl;
            req_addr  = ~addr;
            req_wdata = ~wd;
            @(negedge clk);
            lat++;
            req_start = 1'b0;
        end
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = wr ? WR_CYCLES : RD_CYCLES;
        chk(done == 1'b1, "R9", "done seen", 64'(done), 64'h1);
        chk(lat == exp_lat, "R9", "done latency", 64'(lat), 64'(exp_lat));
        chk(busy == 1'b1, "R9", "busy with done", 64'(busy), 64'h1);
        chk({sio_cs_oe, sio_clk_oe, sio_dout_oe} == 3'b000, "R9", "pins released at done",
            64'({sio_cs_oe, sio_clk_oe, sio_dout_oe}), 64'h0);
        chk(rd_data == exp_result(wr, tbl, addr, p), wr ? "R9" : "R7", "result",
            64'(rd_data), 64'(exp_result(wr, tbl, addr, p)));
        if (wr) begin
            chk(rises == 29, "R8", "rising edge count", 64'(rises), 64'd29);
            for (int i = 0; i < 27; i++) got_wr[26 - i] = log_d[i];
            chk(got_wr == exp_wr_frame(addr, wd), "R8", "write frame",
                64'(got_wr), 64'(exp_wr_frame(addr, wd)));
            chk(log_cs[26:0] == '1 && log_cs[28:27] == 2'b00, "R8", "select pattern",
                64'(log_cs[28:0]), 64'h07FF_FFFF);
        end else begin
            chk(rises == 82, "R6", "rising edge count", 64'(rises), 64'd82);
            for (int i = 0; i < 46; i++) got_rd[45 - i] = log_d[i];
            chk(got_rd == exp_rd_frame(tbl, addr), "R5", "read frame",
                64'(got_rd), 64'(exp_rd_frame(tbl, addr)));
            chk(log_cs[81:0] == '0, "R5", "select low", 64'(log_cs[63:0]), 64'h0);
            chk(log_oe[45:0] == '1, "R6", "data driven in command",
                64'(log_oe[45:0]), 64'h3FFF_FFFF_FFFF);
            chk(log_oe[81:46] == '0, "R6", "data released after command",
                64'(log_oe[81:46]), 64'h0);
        end
        @(negedge clk);
        chk(!done && !busy, "R9", "idle after done", 64'({done, busy}), 64'h0);
        if (poke) chk(1'b1, "R3", "busy start ignored (frame checks above)", 64'h0, 64'h0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL WATCHDOG run did not finish actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [31:0] r;
        logic [31:0] seed_val;
        seed_val = $urandom(32'h5EED_1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, sio_clk, sio_cs_oe, sio_clk_oe, sio_dout_oe} == 6'b0, "R1", "reset state",
            64'({busy, done, sio_clk, sio_cs_oe, sio_clk_oe, sio_dout_oe}), 64'h0);

        // directed corners
        run_txn(1'b0, 1'b0, 8'h12, 16'h0, 32'hA5C3_3C5A, 1'b0); // R7 even half
        run_txn(1'b0, 1'b0, 8'h13, 16'h0, 32'hA5C3_3C5A, 1'b0); // R7 odd half
        run_txn(1'b0, 1'b1, 8'h7F, 16'h0, 32'h8000_0001, 1'b0); // R7 full counter
        run_txn(1'b0, 1'b0, 8'h00, 16'h0, 32'hFFFF_0000, 1'b0);
        run_txn(1'b1, 1'b0, 8'hFF, 16'hFFFF, 32'h0, 1'b0);     // R8 all ones
        run_txn(1'b1, 1'b0, 8'h00, 16'h0000, 32'h0, 1'b0);     // R8 all zeros
        run_txn(1'b1, 1'b0, 8'h5A, 16'h1234, 32'h0, 1'b1);     // R3 during write
        run_txn(1'b0, 1'b0, 8'h21, 16'h0, 32'h1357_9BDF, 1'b1); // R3 during read

        // random mix
        for (int n = 0; n < 14; n++) begin
            r = $urandom;
            run_txn(r[0], r[1], r[9:2], r[25:10], $urandom, 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule